// File: doc/BRIEF.md
# Consistency Violation Tracking Queue

This block sits beside one core of a multicore chip. It keeps ordering metadata for each of the core's own loads and stores that are still able to take part in a sequential-consistency violation. Each resident entry holds the access address and its sequence number. For every other core it also holds a lower bound on the sequence numbers that may depend on this access, and an upper bound on the sequence numbers this access may depend on. It never holds data. When the coherence fabric reports a dependence between a local access and a remote one, the block compares the remote sequence number with the stored bounds. A violation of a bound raises an exception. Otherwise the bounds of the affected entry are tightened, and the new value is carried to the older entries (upper bounds, by minimum) or to the younger entries (lower bounds, by maximum).

Entries are allocated in program order into a circular buffer. An entry is marked safe from outside once it has performed and every access it constrains on other cores has performed. Only the oldest entry retires, and only when it is safe. A counting Bloom filter over resident addresses screens remote snoops. When the filter reports no possible resident copy, the block skips the search and answers the snoop without checking it. The same check serves read-after-write, write-after-write and write-after-read dependences, because only the direction of the dependence matters.

Top module: `scv_track_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1, `alloc_slot` is 0, and no response or exception is signalled.
- R2: An allocation writes the slot shown on `alloc_slot`. Slots are handed out in increasing order and wrap modulo DEPTH. With DEPTH entries resident, `alloc_ready` is 0 and an allocation request is ignored: its address stays absent from the filter.
- R3: A snoop from a remote core whose address hits a resident entry gets a response one cycle later with `rsp_hit`=1 and `rsp_sn` equal to that entry's sequence number. If the snoop number is less than or equal to the entry's lower bound for that core, `exc_prod_valid` is raised in the same cycle as the response, naming the entry slot and the core.
- R4: A hitting snoop that raises no exception lowers the upper bound for that core, on the matched entry and on every older entry, to the minimum of the current value and the snoop number. Younger entries are left unchanged.
- R5: A dependence reported on a local slot from a remote core raises `exc_cons_valid` one cycle later, naming the slot and the core, when its number is greater than or equal to that slot's upper bound for that core.
- R6: A dependence that raises no exception raises the lower bound for that core, on the named slot and on every younger entry, to the maximum of the current value and the dependence number.
- R7: The bounds are kept separately per remote core. Tightening them for one core leaves the checks for another core unchanged.
- R8: A newly allocated entry constrains nothing. Its lower bounds are 0 and its upper bounds are all ones, so sequence numbers 1 to all-ones-minus-one raise no exception against it. The value 0 is reserved.
- R9: A snoop whose address is screened out by the filter, or that matches no resident entry, is answered with `rsp_hit`=0 and `rsp_sn`=0. It raises no exception and changes no bound.
- R10: A snoop or dependence that carries the local core's own ID is ignored. It produces no response and no exception.
- R11: Only the oldest entry retires, and only after it has been marked safe. Marking a younger entry safe frees no space. Retiring an entry removes its address from the filter, so later snoops to that address miss.
- R12: When a snoop and a dependence arrive in the same cycle, both are judged against the bounds as they stood before that cycle, and both updates are applied.
- R13: When several resident entries share the snooped address, the youngest of them is the matched entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry for a newly issued access |
| alloc_addr | input | ADDR_W | Address of the access |
| alloc_sn | input | SN_W | Sequence number of the access (nonzero) |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_slot | output | PTR_W | Slot the next allocation will occupy |
| snp_valid | input | 1 | Remote request touching a local access |
| snp_core | input | CID_W | Requesting core ID |
| snp_addr | input | ADDR_W | Requested address |
| snp_sn | input | SN_W | Requester's sequence number |
| rsp_valid | output | 1 | Response to the previous cycle's snoop |
| rsp_hit | output | 1 | A resident entry matched and was checked |
| rsp_core | output | CID_W | Core the response is addressed to |
| rsp_sn | output | SN_W | Matched entry's sequence number, else 0 |
| dep_valid | input | 1 | Response received for a local access |
| dep_core | input | CID_W | Responding core ID |
| dep_slot | input | PTR_W | Local slot the response belongs to |
| dep_sn | input | SN_W | Responder's sequence number |
| done_valid | input | 1 | Mark a slot safe |
| done_slot | input | PTR_W | Slot to mark safe |
| exc_prod_valid | output | 1 | Violation found while answering a snoop |
| exc_prod_slot | output | PTR_W | Offending local slot |
| exc_prod_core | output | CID_W | Remote core involved |
| exc_cons_valid | output | 1 | Violation found on a received dependence |
| exc_cons_slot | output | PTR_W | Offending local slot |
| exc_cons_core | output | CID_W | Remote core involved |

## Verification
A snoop and a dependence from the same remote core can land in one cycle on the same entry. The snoop tightens that entry's upper bound while the dependence is checked against it and raises its lower bound. The bench drives both in one cycle. The dependence number is chosen to lie below the old upper bound but not below the new one, and the snoop number lies above the old lower bound but not above the new one. It then requires that neither exception fires. Follow-up snoops and dependences then show that both new bounds took effect.

// File: rtl/scvq_pkg.sv
package scvq_pkg;
   typedef enum logic [0:0] {
      HASH_LOW  = 1'b0,
      HASH_FOLD = 1'b1
   } hash_e;
endpackage

// File: rtl/scvq_bloom.sv
module scvq_bloom #(
   parameter int              ADDR_W = 16,
   parameter int              SLOTS  = 64,
   parameter int              CNT_W  = 5,
   parameter scvq_pkg::hash_e HASH   = scvq_pkg::HASH_FOLD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_en,
   input  logic [ADDR_W-1:0] inc_addr,
   input  logic              dec_en,
   input  logic [ADDR_W-1:0] dec_addr,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              q_hit
);
   localparam int HW = $clog2(SLOTS);

   if (SLOTS < 2 || (1 << HW) != SLOTS) begin : g_bad_slots
      $error("scvq_bloom: SLOTS must be a power of two, at least 2");
   end
   if (ADDR_W < HW) begin : g_bad_addr
      $error("scvq_bloom: ADDR_W narrower than the hash index");
   end

   logic [HW-1:0] h_inc, h_dec, h_q;

   if (HASH == scvq_pkg::HASH_LOW) begin : g_low
      assign h_inc = inc_addr[HW-1:0];
      assign h_dec = dec_addr[HW-1:0];
      assign h_q   = q_addr[HW-1:0];
   end else begin : g_fold
      function automatic logic [HW-1:0] fold(input logic [ADDR_W-1:0] a);
         logic [HW-1:0] h;
         h = '0;
         for (int b = 0; b < ADDR_W; b++) h[b % HW] ^= a[b];
         return h;
      endfunction
      assign h_inc = fold(inc_addr);
      assign h_dec = fold(dec_addr);
      assign h_q   = fold(q_addr);
   end

   logic [CNT_W-1:0] cnt_q [SLOTS];

   always_ff @(posedge clk) begin
      for (int s = 0; s < SLOTS; s++) begin
         if (!rst_n) begin
            cnt_q[s] <= '0;
         end else begin
            if (inc_en && h_inc == HW'(s) && !(dec_en && h_dec == HW'(s)))
               cnt_q[s] <= cnt_q[s] + 1'b1;
            else if (dec_en && h_dec == HW'(s) && !(inc_en && h_inc == HW'(s)))
               cnt_q[s] <= cnt_q[s] - 1'b1;
         end
      end
   end

   assign q_hit = (cnt_q[h_q] != '0);
endmodule

// File: rtl/scvq_entry.sv
module scvq_entry #(
   parameter int ADDR_W = 16,
   parameter int SN_W   = 16,
   parameter int NR     = 7,
   parameter int RID_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ADDR_W-1:0]        addr_in,
   input  logic [SN_W-1:0]          sn_in,
   input  logic                     ub_en,
   input  logic [RID_W-1:0]         ub_rid,
   input  logic [SN_W-1:0]          ub_val,
   input  logic                     lb_en,
   input  logic [RID_W-1:0]         lb_rid,
   input  logic [SN_W-1:0]          lb_val,
   output logic [ADDR_W-1:0]        addr_q,
   output logic [SN_W-1:0]          sn_q,
   output logic [NR-1:0][SN_W-1:0]  ub_q,
   output logic [NR-1:0][SN_W-1:0]  lb_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         addr_q <= rst_n ? addr_in : '0;
         sn_q   <= rst_n ? sn_in : '0;
         for (int r = 0; r < NR; r++) begin
            ub_q[r] <= '1;
            lb_q[r] <= '0;
         end
      end else begin
         for (int r = 0; r < NR; r++) begin
            if (ub_en && ub_rid == RID_W'(r) && ub_val < ub_q[r]) ub_q[r] <= ub_val;
            if (lb_en && lb_rid == RID_W'(r) && lb_val > lb_q[r]) lb_q[r] <= lb_val;
         end
      end
   end
endmodule

// File: rtl/scv_track_queue.sv
module scv_track_queue #(
   parameter int              DEPTH       = 16,
   parameter int              NCORES      = 8,
   parameter int              LOCAL_ID    = 0,
   parameter int              ADDR_W      = 16,
   parameter int              SN_W        = 16,
   parameter int              BLOOM_SLOTS = 64,
   parameter scvq_pkg::hash_e HASH        = scvq_pkg::HASH_FOLD,
   localparam int             PTR_W       = $clog2(DEPTH),
   localparam int             CID_W       = $clog2(NCORES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [SN_W-1:0]   alloc_sn,
   output logic              alloc_ready,
   output logic [PTR_W-1:0]  alloc_slot,
   input  logic              snp_valid,
   input  logic [CID_W-1:0]  snp_core,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [SN_W-1:0]   snp_sn,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [CID_W-1:0]  rsp_core,
   output logic [SN_W-1:0]   rsp_sn,
   input  logic              dep_valid,
   input  logic [CID_W-1:0]  dep_core,
   input  logic [PTR_W-1:0]  dep_slot,
   input  logic [SN_W-1:0]   dep_sn,
   input  logic              done_valid,
   input  logic [PTR_W-1:0]  done_slot,
   output logic              exc_prod_valid,
   output logic [PTR_W-1:0]  exc_prod_slot,
   output logic [CID_W-1:0]  exc_prod_core,
   output logic              exc_cons_valid,
   output logic [PTR_W-1:0]  exc_cons_slot,
   output logic [CID_W-1:0]  exc_cons_core
);
   localparam int NR    = NCORES - 1;
   localparam int RID_W = (NCORES > 2) ? $clog2(NCORES - 1) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("scv_track_queue: DEPTH must be a power of two, at least 2");
   end
   if (NCORES < 2 || (1 << CID_W) != NCORES) begin : g_bad_cores
      $error("scv_track_queue: NCORES must be a power of two, at least 2");
   end
   if (LOCAL_ID < 0 || LOCAL_ID >= NCORES) begin : g_bad_local
      $error("scv_track_queue: LOCAL_ID out of range");
   end
   if (SN_W < 2) begin : g_bad_sn
      $error("scv_track_queue: SN_W too narrow");
   end

   function automatic logic [RID_W-1:0] to_rid(input logic [CID_W-1:0] c);
      logic [CID_W-1:0] t;
      t = (c > CID_W'(LOCAL_ID)) ? c - 1'b1 : c;
      return RID_W'(t);
   endfunction

   // ---------------- occupancy ----------------
   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] count_q;
   logic [DEPTH-1:0] vld_q, safe_q;
   logic             do_alloc, retire_w;

   assign alloc_ready = (count_q != CNT_W'(DEPTH));
   assign alloc_slot  = tail_q;
   assign do_alloc    = alloc_valid && alloc_ready;
   assign retire_w    = vld_q[head_q] && safe_q[head_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
         vld_q   <= '0;
         safe_q  <= '0;
      end else begin
         if (do_alloc) tail_q <= tail_q + 1'b1;
         if (retire_w) head_q <= head_q + 1'b1;
         count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(retire_w);
         for (int i = 0; i < DEPTH; i++) begin
            if (retire_w && head_q == PTR_W'(i)) begin
               vld_q[i]  <= 1'b0;
               safe_q[i] <= 1'b0;
            end else if (do_alloc && tail_q == PTR_W'(i)) begin
               vld_q[i]  <= 1'b1;
               safe_q[i] <= 1'b0;
            end else if (done_valid && done_slot == PTR_W'(i) && vld_q[i]) begin
               safe_q[i] <= 1'b1;
            end
         end
      end
   end

   // ---------------- entry storage ----------------
   logic [ADDR_W-1:0]       ent_addr [DEPTH];
   logic [SN_W-1:0]         ent_sn   [DEPTH];
   logic [NR-1:0][SN_W-1:0] ent_ub   [DEPTH];
   logic [NR-1:0][SN_W-1:0] ent_lb   [DEPTH];
   logic [DEPTH-1:0]        ub_en, lb_en;
   logic [RID_W-1:0]        snp_rid, dep_rid;

   assign snp_rid = to_rid(snp_core);
   assign dep_rid = to_rid(dep_core);

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      scvq_entry #(
         .ADDR_W(ADDR_W), .SN_W(SN_W), .NR(NR), .RID_W(RID_W)
      ) u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (do_alloc && tail_q == PTR_W'(g)),
         .addr_in (alloc_addr),
         .sn_in   (alloc_sn),
         .ub_en   (ub_en[g]),
         .ub_rid  (snp_rid),
         .ub_val  (snp_sn),
         .lb_en   (lb_en[g]),
         .lb_rid  (dep_rid),
         .lb_val  (dep_sn),
         .addr_q  (ent_addr[g]),
         .sn_q    (ent_sn[g]),
         .ub_q    (ent_ub[g]),
         .lb_q    (ent_lb[g])
      );
   end

   // ---------------- filter ----------------
   logic bloom_hit;

   scvq_bloom #(
      .ADDR_W(ADDR_W), .SLOTS(BLOOM_SLOTS), .CNT_W(CNT_W), .HASH(HASH)
   ) u_bloom (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_en   (do_alloc),
      .inc_addr (alloc_addr),
      .dec_en   (retire_w),
      .dec_addr (ent_addr[head_q]),
      .q_addr   (snp_addr),
      .q_hit    (bloom_hit)
   );

   // ---------------- producer side: youngest matching entry ----------------
   logic [PTR_W-1:0] age [DEPTH];
   logic [PTR_W-1:0] best_slot, best_age, dep_age;
   logic             any_match, snp_ok, prod_chk, prod_exc;
   logic             dep_ok, cons_exc;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) age[i] = PTR_W'(i) - head_q;
   end

   always_comb begin
      any_match = 1'b0;
      best_slot = '0;
      best_age  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (vld_q[i] && ent_addr[i] == snp_addr && (!any_match || age[i] >= best_age)) begin
            any_match = 1'b1;
            best_slot = PTR_W'(i);
            best_age  = age[i];
         end
      end
   end

   assign snp_ok   = snp_valid && snp_core != CID_W'(LOCAL_ID);
   assign prod_chk = snp_ok && bloom_hit && any_match;
   assign prod_exc = prod_chk && (snp_sn <= ent_lb[best_slot][snp_rid]);

   // ---------------- consumer side ----------------
   assign dep_age  = age[dep_slot];
   assign dep_ok   = dep_valid && dep_core != CID_W'(LOCAL_ID) && vld_q[dep_slot];
   assign cons_exc = dep_ok && (dep_sn >= ent_ub[dep_slot][dep_rid]);

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         ub_en[i] = prod_chk && !prod_exc && vld_q[i] && age[i] <= best_age;
         lb_en[i] = dep_ok && !cons_exc && vld_q[i] && age[i] >= dep_age;
      end
   end

   // ---------------- registered outputs ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_core       <= '0;
         rsp_sn         <= '0;
         exc_prod_valid <= 1'b0;
         exc_prod_slot  <= '0;
         exc_prod_core  <= '0;
         exc_cons_valid <= 1'b0;
         exc_cons_slot  <= '0;
         exc_cons_core  <= '0;
      end else begin
         rsp_valid      <= snp_ok;
         rsp_hit        <= prod_chk;
         rsp_core       <= snp_core;
         rsp_sn         <= prod_chk ? ent_sn[best_slot] : '0;
         exc_prod_valid <= prod_exc;
         exc_prod_slot  <= best_slot;
         exc_prod_core  <= snp_core;
         exc_cons_valid <= cons_exc;
         exc_cons_slot  <= dep_slot;
         exc_cons_core  <= dep_core;
      end
   end
endmodule

// File: rtl/scvq_checker.sv
module scvq_checker #(
   parameter int DEPTH    = 16,
   parameter int NCORES   = 8,
   parameter int LOCAL_ID = 0,
   parameter int SN_W     = 16,
   parameter int PTR_W    = 4,
   parameter int CID_W    = 3,
   parameter int CNT_W    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             snp_valid,
   input logic [CID_W-1:0] snp_core,
   input logic             dep_valid,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic [SN_W-1:0]  rsp_sn,
   input logic             exc_prod_valid,
   input logic             exc_cons_valid,
   input logic             alloc_ready,
   input logic [CNT_W-1:0] count_q,
   input logic [PTR_W-1:0] tail_q,
   input logic             retire_w
);
   p_rsp_follows_snoop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_core != CID_W'(LOCAL_ID)) |=> rsp_valid);

   p_prod_exc_with_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exc_prod_valid |-> (rsp_valid && rsp_hit));

   p_own_core_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_core == CID_W'(LOCAL_ID)) |=> (!rsp_valid && !exc_prod_valid));

   p_miss_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_sn == '0 && !exc_prod_valid));

   p_cons_exc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_cons_valid |-> $past(dep_valid));

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));

   p_full_holds_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_W'(DEPTH)) |=> $stable(tail_q));

   p_retire_frees_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_w && !alloc_ready) |=> alloc_ready);
endmodule

bind scv_track_queue scvq_checker #(
   .DEPTH(DEPTH), .NCORES(NCORES), .LOCAL_ID(LOCAL_ID), .SN_W(SN_W),
   .PTR_W(PTR_W), .CID_W(CID_W), .CNT_W(CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .snp_valid      (snp_valid),
   .snp_core       (snp_core),
   .dep_valid      (dep_valid),
   .rsp_valid      (rsp_valid),
   .rsp_hit        (rsp_hit),
   .rsp_sn         (rsp_sn),
   .exc_prod_valid (exc_prod_valid),
   .exc_cons_valid (exc_cons_valid),
   .alloc_ready    (alloc_ready),
   .count_q        (count_q),
   .tail_q         (tail_q),
   .retire_w       (retire_w)
);

// File: tb/scv_track_queue_bench.sv
module scv_track_queue_bench;
   localparam int DEPTH = 4, NCORES = 4, LOCAL_ID = 1, ADDR_W = 8, SN_W = 8;
   localparam int PTR_W = 2, CID_W = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic alloc_valid = 0; logic [ADDR_W-1:0] alloc_addr = 0; logic [SN_W-1:0] alloc_sn = 0;
   logic alloc_ready; logic [PTR_W-1:0] alloc_slot;
   logic snp_valid = 0; logic [CID_W-1:0] snp_core = 0;
   logic [ADDR_W-1:0] snp_addr = 0; logic [SN_W-1:0] snp_sn = 0;
   logic rsp_valid, rsp_hit; logic [CID_W-1:0] rsp_core; logic [SN_W-1:0] rsp_sn;
   logic dep_valid = 0; logic [CID_W-1:0] dep_core = 0;
   logic [PTR_W-1:0] dep_slot = 0; logic [SN_W-1:0] dep_sn = 0;
   logic done_valid = 0; logic [PTR_W-1:0] done_slot = 0;
   logic exc_prod_valid, exc_cons_valid;
   logic [PTR_W-1:0] exc_prod_slot, exc_cons_slot;
   logic [CID_W-1:0] exc_prod_core, exc_cons_core;

   scv_track_queue #(
      .DEPTH(DEPTH), .NCORES(NCORES), .LOCAL_ID(LOCAL_ID), .ADDR_W(ADDR_W),
      .SN_W(SN_W), .BLOOM_SLOTS(16), .HASH(scvq_pkg::HASH_FOLD)
   ) u_scv_track_queue (.*);

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_alloc(input int addr, input int sn, input int exp_slot);
      @(negedge clk);
      check(alloc_slot == PTR_W'(exp_slot), "R2 alloc slot", alloc_slot, exp_slot);
      alloc_valid = 1; alloc_addr = ADDR_W'(addr); alloc_sn = SN_W'(sn);
      tick();
      alloc_valid = 0;
   endtask

   task automatic snoop(input int core, input int addr, input int sn,
                        input bit exp_hit, input int exp_sn, input bit exp_exc,
                        input int exp_slot, input string req);
      @(negedge clk);
      snp_valid = 1; snp_core = CID_W'(core); snp_addr = ADDR_W'(addr); snp_sn = SN_W'(sn);
      tick();
      snp_valid = 0;
      check(rsp_valid && rsp_core == CID_W'(core), {req, " rsp valid"}, rsp_valid, 1);
      check(rsp_hit == exp_hit && rsp_sn == SN_W'(exp_sn), {req, " rsp sn"}, rsp_sn, exp_sn);
      check(exc_prod_valid == exp_exc, {req, " prod exc"}, exc_prod_valid, exp_exc);
      if (exp_exc)
         check(exc_prod_slot == PTR_W'(exp_slot) && exc_prod_core == CID_W'(core),
               {req, " prod exc slot"}, exc_prod_slot, exp_slot);
   endtask

   task automatic depend(input int core, input int slot, input int sn,
                         input bit exp_exc, input string req);
      @(negedge clk);
      dep_valid = 1; dep_core = CID_W'(core); dep_slot = PTR_W'(slot); dep_sn = SN_W'(sn);
      tick();
      dep_valid = 0;
      check(exc_cons_valid == exp_exc, {req, " cons exc"}, exc_cons_valid, exp_exc);
      if (exp_exc)
         check(exc_cons_slot == PTR_W'(slot) && exc_cons_core == CID_W'(core),
               {req, " cons exc slot"}, exc_cons_slot, slot);
   endtask

   task automatic mark_done(input int slot);
      @(negedge clk);
      done_valid = 1; done_slot = PTR_W'(slot);
      tick();
      done_valid = 0;
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      check(alloc_ready == 1 && alloc_slot == 0, "R1 empty", alloc_ready, 1);
      check(!rsp_valid && !exc_prod_valid && !exc_cons_valid, "R1 quiet", rsp_valid, 0);
   endtask

   task automatic t_basic();
      do_alloc(8'h10, 5, 0);
      do_alloc(8'h20, 6, 1);
      snoop(2, 8'h10, 3, 1, 5, 0, 0, "R8 fresh entry");
      snoop(2, 8'h55, 9, 0, 0, 0, 0, "R9 filter miss");
      depend(2, 0, 3, 1, "R4 upper bound tightened");
      depend(2, 1, 200, 0, "R4 younger untouched");
      snoop(2, 8'h20, 150, 1, 6, 1, 1, "R6 lower bound raised");
      snoop(3, 8'h20, 150, 1, 6, 0, 0, "R7 other core independent");
      depend(2, 0, 2, 0, "R5 below bound");
      snoop(2, 8'h10, 2, 1, 5, 1, 0, "R3 equal to lower bound");
   endtask

   task automatic t_youngest();
      do_alloc(8'h10, 7, 2);
      snoop(0, 8'h10, 4, 1, 7, 0, 0, "R13 youngest match");
      depend(0, 2, 4, 1, "R5 equal to upper bound");
      depend(0, 0, 3, 0, "R6 propagate younger");
      snoop(0, 8'h20, 3, 1, 6, 1, 1, "R6 younger entry raised");
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      snp_valid = 1; snp_core = 3; snp_addr = 8'h20; snp_sn = 20;
      dep_valid = 1; dep_core = 3; dep_slot = 1; dep_sn = 30;
      tick();
      snp_valid = 0; dep_valid = 0;
      check(rsp_hit && rsp_sn == 6, "R12 rsp", rsp_sn, 6);
      check(!exc_prod_valid, "R12 no prod exc", exc_prod_valid, 0);
      check(!exc_cons_valid, "R12 no cons exc", exc_cons_valid, 0);
      snoop(3, 8'h20, 25, 1, 6, 1, 1, "R12 lower bound applied");
      depend(3, 1, 20, 1, "R12 upper bound applied");
   endtask

   task automatic t_full_retire();
      do_alloc(8'h30, 8, 3);
      check(alloc_ready == 0, "R2 full", alloc_ready, 0);
      @(negedge clk);
      alloc_valid = 1; alloc_addr = 8'h40; alloc_sn = 9;
      tick();
      alloc_valid = 0;
      snoop(0, 8'h40, 9, 0, 0, 0, 0, "R2 ignored when full");
      mark_done(1);
      tick();
      check(alloc_ready == 0, "R11 younger done frees nothing", alloc_ready, 0);
      mark_done(0);
      tick(); tick();
      check(alloc_ready == 1, "R11 head retired", alloc_ready, 1);
      snoop(3, 8'h20, 40, 0, 0, 0, 0, "R11 retired address gone");
      snoop(0, 8'h10, 90, 1, 7, 0, 0, "R11 resident entry kept");
      do_alloc(8'h40, 9, 0);
   endtask

   task automatic t_own_core();
      @(negedge clk);
      snp_valid = 1; snp_core = CID_W'(LOCAL_ID); snp_addr = 8'h10; snp_sn = 1;
      dep_valid = 1; dep_core = CID_W'(LOCAL_ID); dep_slot = 2; dep_sn = 250;
      tick();
      snp_valid = 0; dep_valid = 0;
      check(!rsp_valid && !exc_prod_valid, "R10 own snoop ignored", rsp_valid, 0);
      check(!exc_cons_valid, "R10 own dep ignored", exc_cons_valid, 0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_youngest();
      t_same_cycle();
      t_full_retire();
      t_own_core();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule